// File: doc/BRIEF.md
# External Interrupt Exception Entry

This block decides when a pending level-sensitive external interrupt request is accepted by a simple in-order core, and produces everything the core needs to enter the handler in one step. It produces the fetch redirect, the saved return address, the saved machine state and the handler-entry machine state register (MSR) value. The request is only looked at on an instruction-boundary strobe, and only while the MSR external-enable bit is set. The level of the line at that moment is what counts. A request that went away before the strobe leaves no trace.

When the request is accepted, the block raises a one-cycle taken pulse on the clock edge after the strobe. In that same cycle it presents four values:

- the handler address, at a fixed offset from one of two bases selected by the MSR interrupt-prefix bit;
- the new SRR0, which is the address of the instruction that would have run next;
- the new SRR1, which holds the lower half of the MSR, with the upper half zero;
- the new MSR, with the handler-entry bit updates applied.

The core writes these into its registers. Because the entry MSR has external-enable cleared, a line that stays high does not fire again until software sets the enable bit. The block also refuses to accept a request in the cycle in which its own MSR write is landing.

Top module: `ext_irq_entry`

MSR bits are numbered from the least significant bit, bit 0.

## Requirements
- R1: A request is accepted only at a clock edge where `boundary_i` is 1, `irq_i` is 1 and MSR external-enable (bit 15) is 1. With bit 15 clear, the request is ignored and `taken_o` stays 0.
- R2: Only the live level of `irq_i` at the strobe edge counts. A request that was high between strobes and is low at a strobe edge causes no entry then or later.
- R3: `taken_o` and `redirect_valid_o` rise together for exactly one cycle, registered one clock after the accepting edge. No request is accepted at an edge where `taken_o` is already 1, so two entries are never in consecutive cycles.
- R4: The redirect target is `VEC_OFFSET` (default 0x0000_0500) when MSR interrupt-prefix (bit 6) was 0. It is `HIGH_BASE + VEC_OFFSET` (default 0xFFF0_0500) when bit 6 was 1.
- R5: On entry `srr0_o` equals the `next_pc_i` value present at the accepting edge.
- R6: On entry `srr1_o[15:0]` equals MSR bits 15:0 at the accepting edge, and `srr1_o[31:16]` is zero.
- R7: On entry `msr_next_o` has the following bits cleared: 18 (power save), 17 (temporary GPR), 15 (external enable), 14 (problem state), 13 (FP available), 11 and 8 (FP exception modes), 10 (single step), 9 (branch trace), 5 (instruction relocate), 4 (data relocate) and 1 (recoverable).
- R8: On entry, bit 0 (little-endian) of `msr_next_o` takes the value of bit 16 (interrupt little-endian). Every other bit keeps its value, including 12 (machine check enable), 7 (critical enable), 6 (prefix) and 16.
- R9: While `rst_n` is 0 at a clock edge, all outputs are cleared to zero.
- R10: The target, SRR0, SRR1 and MSR outputs hold their last entry values in cycles with no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 1 | Level-sensitive external interrupt request |
| boundary_i | input | 1 | Instruction-boundary strobe, the recognition point |
| msr_i | input | 32 | Current machine state register |
| next_pc_i | input | ADDR_W | Address of the next instruction to execute |
| redirect_valid_o | output | 1 | Fetch redirect request, one cycle |
| redirect_target_o | output | ADDR_W | Handler fetch address |
| srr0_o | output | ADDR_W | New save/restore register 0 value |
| srr1_o | output | 32 | New save/restore register 1 value |
| msr_next_o | output | 32 | Handler-entry MSR value |
| taken_o | output | 1 | Interrupt-taken pulse, one cycle |

## Verification
The bench builds the block with its defaults: a 32-bit address, offset 0x500 and high base 0xFFF0_0000. This means both handler addresses are checked as absolute values, and full 32-bit return addresses with all upper bits exercised reach SRR0. Random MSR words cover every cleared and preserved bit position in both polarities. Directed runs with the enable held high and the strobe asserted every cycle exercise the back-to-back suppression.

// File: rtl/ext_irq_pkg.sv
// Package: bit positions in the 32-bit machine state register, LSB-0 numbering.
// Assumes the surrounding core uses the same layout when it writes msr_next_o back.
package ext_irq_pkg;
    localparam int MSR_W     = 32;
    localparam int SRR1_KEEP = 16;   // low bits copied from MSR into SRR1

    localparam int B_POW  = 18;
    localparam int B_TGPR = 17;
    localparam int B_ILE  = 16;
    localparam int B_EE   = 15;
    localparam int B_PR   = 14;
    localparam int B_FP   = 13;
    localparam int B_ME   = 12;
    localparam int B_FE0  = 11;
    localparam int B_SE   = 10;
    localparam int B_BE   = 9;
    localparam int B_FE1  = 8;
    localparam int B_CE   = 7;
    localparam int B_IP   = 6;
    localparam int B_IR   = 5;
    localparam int B_DR   = 4;
    localparam int B_RI   = 1;
    localparam int B_LE   = 0;

    // Bits forced to zero when the handler is entered
    localparam logic [MSR_W-1:0] ENTRY_CLR_MASK =
        (MSR_W'(1) << B_POW) | (MSR_W'(1) << B_TGPR) | (MSR_W'(1) << B_EE)  |
        (MSR_W'(1) << B_PR)  | (MSR_W'(1) << B_FP)   | (MSR_W'(1) << B_FE0) |
        (MSR_W'(1) << B_SE)  | (MSR_W'(1) << B_BE)   | (MSR_W'(1) << B_FE1) |
        (MSR_W'(1) << B_IR)  | (MSR_W'(1) << B_DR)   | (MSR_W'(1) << B_RI);
endpackage

// File: rtl/ext_irq_recog.sv
// Recognition gate: accepts the live request level at an instruction boundary
// when external interrupts are enabled. Assumes 'busy' is high in the cycle the
// previous entry's MSR write is landing, so that cycle is skipped.
module ext_irq_recog (
    input  logic irq,
    input  logic boundary,
    input  logic ee,
    input  logic busy,
    output logic take
);
    // Combine the recognition conditions; no state, so a dropped line is forgotten
    always_comb begin
        take = irq && boundary && ee && !busy;
    end
endmodule

// File: rtl/ext_irq_vector.sv
// Handler address generator: picks the low or high base from the prefix bit
// and adds the fixed external-interrupt offset. Assumes the offset fits ADDR_W.
module ext_irq_vector #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0500,
    parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000
) (
    input  logic              prefix,
    output logic [ADDR_W-1:0] target
);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(VEC_OFFSET);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(HIGH_BASE) + ADDR_W'(VEC_OFFSET);

    // Select the handler address for the current prefix setting
    always_comb begin
        target = prefix ? HI_ADDR : LO_ADDR;
    end
endmodule

// File: rtl/ext_irq_msr_xform.sv
// State transform: builds the saved-state word and the handler-entry MSR from
// the current MSR. Purely combinational; bits not named in the clear mask pass through.
module ext_irq_msr_xform
    import ext_irq_pkg::*;
(
    input  logic [MSR_W-1:0] msr,
    output logic [MSR_W-1:0] srr1,
    output logic [MSR_W-1:0] msr_entry
);
    // Saved state: low half of MSR, upper half zero
    always_comb begin
        srr1 = '0;
        srr1[SRR1_KEEP-1:0] = msr[SRR1_KEEP-1:0];
    end

    // Entry MSR: clear the masked bits, then reload endian mode from the interrupt-endian bit
    always_comb begin
        msr_entry = msr & ~ENTRY_CLR_MASK;
        msr_entry[B_LE] = msr[B_ILE];
    end
endmodule

// File: rtl/ext_irq_entry.sv
// Top: external interrupt entry. Samples the request at instruction boundaries
// and registers the redirect, SRR0/SRR1 and entry MSR for one taken cycle.
// Assumes the core writes the outputs to its registers in the taken cycle and
// presents the updated MSR on msr_i from the following cycle.
module ext_irq_entry
    import ext_irq_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0500,
    parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_i,
    input  logic              boundary_i,
    input  logic [31:0]       msr_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    output logic              redirect_valid_o,
    output logic [ADDR_W-1:0] redirect_target_o,
    output logic [ADDR_W-1:0] srr0_o,
    output logic [31:0]       srr1_o,
    output logic [31:0]       msr_next_o,
    output logic              taken_o
);
    logic              take;
    logic [ADDR_W-1:0] vec_addr;
    logic [MSR_W-1:0]  srr1_d;
    logic [MSR_W-1:0]  msr_d;
    logic              taken_q;

    ext_irq_recog u_recog (
        .irq      (irq_i),
        .boundary (boundary_i),
        .ee       (msr_i[B_EE]),
        .busy     (taken_q),
        .take     (take)
    );

    ext_irq_vector #(
        .ADDR_W     (ADDR_W),
        .VEC_OFFSET (VEC_OFFSET),
        .HIGH_BASE  (HIGH_BASE)
    ) u_vector (
        .prefix (msr_i[B_IP]),
        .target (vec_addr)
    );

    ext_irq_msr_xform u_xform (
        .msr       (msr_i),
        .srr1      (srr1_d),
        .msr_entry (msr_d)
    );

    // Taken pulse register: one cycle per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) taken_q <= 1'b0;
        else        taken_q <= take;
    end

    // Entry payload registers: load on acceptance, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_target_o <= '0;
            srr0_o            <= '0;
            srr1_o            <= '0;
            msr_next_o        <= '0;
        end else if (take) begin
            redirect_target_o <= vec_addr;
            srr0_o            <= next_pc_i;
            srr1_o            <= srr1_d;
            msr_next_o        <= msr_d;
        end
    end

    assign taken_o          = taken_q;
    assign redirect_valid_o = taken_q;

    // R1
    take_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(irq_i && boundary_i && msr_i[B_EE]));

    // R3
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> !taken_o);

    // R4
    vector_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |->
            (($past(msr_i[B_IP]) == 1'b0) && (redirect_target_o == ADDR_W'(VEC_OFFSET))) ||
            (($past(msr_i[B_IP]) == 1'b1) &&
             (redirect_target_o == ADDR_W'(HIGH_BASE) + ADDR_W'(VEC_OFFSET))));

    // R5
    srr0_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> srr0_o == $past(next_pc_i));

    // R6
    srr1_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (srr1_o[31:16] == 16'h0) && (srr1_o[15:0] == $past(msr_i[15:0])));

    // R7
    ee_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> !msr_next_o[B_EE] && !msr_next_o[B_PR] && !msr_next_o[B_IR]);

    // R8
    endian_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (msr_next_o[B_LE] == $past(msr_i[B_ILE])) &&
                    (msr_next_o[B_ME] == $past(msr_i[B_ME])));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken_o && $past(rst_n)) |-> $stable(srr0_o) && $stable(msr_next_o));
endmodule

// File: tb/ext_irq_entry_tb.sv
`timescale 1ns/1ps
module ext_irq_entry_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          irq_i, boundary_i;
    logic [31:0]   msr_i;
    logic [AW-1:0] next_pc_i;
    logic          redirect_valid_o, taken_o;
    logic [AW-1:0] redirect_target_o, srr0_o;
    logic [31:0]   srr1_o, msr_next_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic exp_last = 1'b0;
    logic [AW-1:0] exp_tgt, exp_srr0;
    logic [31:0]   exp_srr1, exp_msr;

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_entry u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .boundary_i(boundary_i),
        .msr_i(msr_i), .next_pc_i(next_pc_i),
        .redirect_valid_o(redirect_valid_o), .redirect_target_o(redirect_target_o),
        .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_next_o(msr_next_o), .taken_o(taken_o)
    );

    function automatic logic [31:0] f_entry_msr(input logic [31:0] m);
        logic [31:0] r;
        r = m & ~32'h0006_EF32;   // bits 18,17,15,14,13,11,10,9,8,5,4,1
        r[0] = m[16];
        return r;
    endfunction

    function automatic logic [AW-1:0] f_target(input logic [31:0] m);
        return m[6] ? 32'hFFF0_0500 : 32'h0000_0500;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus (called at a negedge), then check after the edge
    task automatic cyc(input logic irq, input logic bnd, input logic [31:0] msr, input logic [AW-1:0] pc);
        logic t;
        irq_i = irq; boundary_i = bnd; msr_i = msr; next_pc_i = pc;
        t = irq && bnd && msr[15] && !exp_last;
        if (t) begin
            exp_tgt  = f_target(msr);
            exp_srr0 = pc;
            exp_srr1 = {16'h0, msr[15:0]};
            exp_msr  = f_entry_msr(msr);
        end
        exp_last = t;
        @(posedge clk);
        @(negedge clk);
        check(taken_o == t, "R1/R2/R3 taken", 64'(taken_o), 64'(t));
        check(redirect_valid_o == t, "R3 redirect_valid", 64'(redirect_valid_o), 64'(t));
        check(redirect_target_o == exp_tgt, "R4/R10 target", 64'(redirect_target_o), 64'(exp_tgt));
        check(srr0_o == exp_srr0, "R5/R10 srr0", 64'(srr0_o), 64'(exp_srr0));
        check(srr1_o == exp_srr1, "R6/R10 srr1", 64'(srr1_o), 64'(exp_srr1));
        check(msr_next_o == exp_msr, "R7/R8/R10 msr_next", 64'(msr_next_o), 64'(exp_msr));
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; irq_i = 1'b1; boundary_i = 1'b1; msr_i = '1; next_pc_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset clears everything
        check({taken_o, redirect_valid_o} == 2'b00, "R9 pulses", 64'({taken_o, redirect_valid_o}), 64'd0);
        check((redirect_target_o | srr0_o) == '0 && (srr1_o | msr_next_o) == '0, "R9 payload",
              64'(srr1_o | msr_next_o), 64'd0);
        exp_tgt = '0; exp_srr0 = '0; exp_srr1 = '0; exp_msr = '0;
        rst_n = 1'b1;

        // R1: enable clear -> ignored
        cyc(1'b1, 1'b1, 32'hFFFF_7FFF, 32'h1234_5678);
        // R1: no strobe -> ignored
        cyc(1'b1, 1'b0, 32'h0000_8000, 32'h1000_0004);
        // R2: request high between strobes, low at strobe -> nothing, ever
        cyc(1'b1, 1'b0, 32'h0000_8000, 32'h1000_0008);
        cyc(1'b0, 1'b1, 32'h0000_8000, 32'h1000_000C);
        cyc(1'b0, 1'b1, 32'h0000_8000, 32'h1000_0010);
        // R4 low base, R7/R8 all ones MSR (LE from ILE=1)
        cyc(1'b1, 1'b1, 32'hFFFF_FFBF, 32'hDEAD_BEEC);
        // R3: enable still presented high with strobe -> suppressed in taken cycle
        cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 32'hCAFE_0000);
        // R4 high base, R8 LE reloaded to 0 from ILE=0
        cyc(1'b1, 1'b1, 32'h0000_8041, 32'hFFFF_FFFC);
        cyc(1'b0, 1'b0, 32'h0000_0000, 32'h0);
        // R8 preserved bits ME, CE, IP with others zero
        cyc(1'b1, 1'b1, 32'h0001_90C0, 32'h0000_0100);
        cyc(1'b0, 1'b1, 32'h0000_0000, 32'h0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] m;
            m = $urandom();
            if ($urandom_range(0, 3) != 0) m[15] = 1'b1;
            cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0), m, $urandom());
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule